// File: doc/BRIEF.md
# Windowed Register File with SEC-DED Protection

This block is the integer register file of a 32-bit processor. The file is organised as eight overlapping register windows. Storage is a single bank of flip-flops. One write port and two independent read ports share that bank, so no second copy of the array is kept to feed the second reader. Every stored word is kept together with 7 check bits of a single-error-correcting, double-error-detecting code. Each read port returns the corrected word and reports whether a correction was made or whether the word could not be recovered.

A logical register number 0 to 31 is turned into a physical entry by the current window pointer. Logical 1 to 7 are globals seen by every window. Logical 8 to 31 live on a ring of 16 entries per window. The "in" registers of window w are the same storage as the "out" registers of window (w+1) mod 8. Logical 0 is hard-wired to zero. A test input XORs a mask onto the codeword as it is written, so that stored errors can be created on purpose.

Top module: `winreg_edac`

## Requirements
- R1: While `rst` is high at a clock edge, all read data outputs and all flag outputs are 0 after that edge.
- R2: A read address presented at a rising edge yields that register's stored value on the port's data output after the same edge, held until the next edge (one cycle latency).
- R3: Logical registers 1 to 7 name the same storage in every window.
- R4: With window pointer w, logical 8..15 are slots 0..7 of window w, logical 16..23 are slots 8..15 of window w, and logical 24..31 are slots 0..7 of window (w+1) mod 8. Slots 8..15 of a window are reachable from no other window.
- R5: A read of logical register 0 returns 0 with both flags low, and a write to logical register 0 has no effect.
- R6: A read of the register being written at the same edge returns the value held before the write. The new value is returned by a read at the following edge.
- R7: The two read ports work independently. Each may address any register in the same cycle, including the same one.
- R8: The codeword is 39 bits. Bit i of `wr_flip` inverts codeword bit i as it is stored. A stored word with exactly one inverted bit reads back with the original data, `*_ce`=1 and `*_ue`=0.
- R9: A stored word with exactly two inverted bits reads back with `*_ue`=1 and `*_ce`=0.
- R10: A stored word written with `wr_flip`=0 reads back with its data and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| cwp | input | 3 | Current window pointer |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical write register |
| wr_data | input | 32 | Write data |
| wr_flip | input | 39 | Test mask XORed onto the stored codeword |
| ra_addr | input | 5 | Logical register for read port A |
| rb_addr | input | 5 | Logical register for read port B |
| ra_data | output | 32 | Corrected data of port A |
| ra_ce | output | 1 | Port A single-bit error was corrected |
| ra_ue | output | 1 | Port A uncorrectable error |
| rb_data | output | 32 | Corrected data of port B |
| rb_ce | output | 1 | Port B single-bit error was corrected |
| rb_ue | output | 1 | Port B uncorrectable error |

## Verification
A wrong window mapping or a stale stored word does not show up until that exact register is read. The output then shows it one cycle after the read address is presented, either as wrong data or as a flag on a word that was written clean. A reference model therefore tracks every physical entry and is compared with both ports on every cycle, across random window pointers. Directed sequences target the overlap, the globals, the write/read collision and the two injected error weights.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int DATA_W  = 32;
  localparam int CHK_W   = 7;
  localparam int CW_W    = DATA_W + CHK_W;
  localparam int NPAR    = CHK_W - 1;

  function automatic logic [CW_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    int j;
    cw = '0;
    j = 0;
    for (int i = 1; i < CW_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        cw[i] = d[j];
        j++;
      end
    end
    for (int k = 0; k < NPAR; k++) begin
      logic p;
      p = 1'b0;
      for (int i = 1; i < CW_W; i++)
        if (((i >> k) & 1) == 1) p = p ^ cw[i];
      cw[1 << k] = p;
    end
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic logic [DATA_W-1:0] secded_extract(input logic [CW_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int i = 1; i < CW_W; i++) begin
      if ((i & (i - 1)) != 0) begin
        d[j] = cw[i];
        j++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/rf_map.sv
module rf_map #(
  parameter int NWIN  = 8,
  parameter int NGLOB = 8,
  parameter int WW    = $clog2(NWIN),
  parameter int PW    = $clog2(NGLOB + NWIN * 16)
) (
  input  logic [WW-1:0] win,
  input  logic [4:0]    lreg,
  output logic [PW-1:0] phys
);
  logic [WW-1:0] next_win;
  int            off;

  always_comb begin
    next_win = (int'(win) == NWIN - 1) ? '0 : win + 1'b1;
    if (lreg < 5'd8)
      off = int'(lreg);
    else if (lreg < 5'd24)
      off = NGLOB + int'(win) * 16 + (int'(lreg) - 8);
    else
      off = NGLOB + int'(next_win) * 16 + (int'(lreg) - 24);
    phys = PW'(off);
  end
endmodule

// File: rtl/rf_secded_dec.sv
module rf_secded_dec
  import winreg_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data,
  output logic              ce,
  output logic              ue
);
  logic [NPAR-1:0] syn;
  logic            odd;
  logic [CW_W-1:0] fixed;

  always_comb begin
    for (int k = 0; k < NPAR; k++) begin
      syn[k] = 1'b0;
      for (int i = 1; i < CW_W; i++)
        if (((i >> k) & 1) == 1) syn[k] = syn[k] ^ cw[i];
    end
    odd   = ^cw;
    fixed = cw;
    ce    = 1'b0;
    ue    = 1'b0;
    if (odd) begin
      if (int'(syn) < CW_W) begin
        fixed[syn] = ~cw[syn];
        ce = 1'b1;
      end else begin
        ue = 1'b1;
      end
    end else if (syn != '0) begin
      ue = 1'b1;
    end
    data = secded_extract(fixed);
  end
endmodule

// File: rtl/winreg_edac.sv
module winreg_edac
  import winreg_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int NGLOB = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          cwp,
  input  logic                wr_en,
  input  logic [4:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [CW_W-1:0]     wr_flip,
  input  logic [4:0]          ra_addr,
  input  logic [4:0]          rb_addr,
  output logic [DATA_W-1:0]   ra_data,
  output logic                ra_ce,
  output logic                ra_ue,
  output logic [DATA_W-1:0]   rb_data,
  output logic                rb_ce,
  output logic                rb_ue
);
  localparam int NPHYS = NGLOB + NWIN * 16;
  localparam int PW    = $clog2(NPHYS);
  localparam int WW    = $clog2(NWIN);
  localparam int NRD   = 2;

  logic [CW_W-1:0]   mem [NPHYS];
  logic [PW-1:0]     wphys;
  logic [4:0]        raddr  [NRD];
  logic [DATA_W-1:0] q_data [NRD];
  logic              q_ce   [NRD];
  logic              q_ue   [NRD];

  assign raddr[0] = ra_addr;
  assign raddr[1] = rb_addr;

  rf_map #(.NWIN(NWIN), .NGLOB(NGLOB), .WW(WW), .PW(PW)) u_wmap (
    .win(cwp[WW-1:0]), .lreg(wr_addr), .phys(wphys)
  );

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr != 5'd0)
      mem[wphys] <= secded_enc(wr_data) ^ wr_flip;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [PW-1:0]     rphys;
    logic [DATA_W-1:0] dec_data;
    logic              dec_ce;
    logic              dec_ue;

    rf_map #(.NWIN(NWIN), .NGLOB(NGLOB), .WW(WW), .PW(PW)) u_rmap (
      .win(cwp[WW-1:0]), .lreg(raddr[p]), .phys(rphys)
    );

    rf_secded_dec u_dec (
      .cw(mem[rphys]), .data(dec_data), .ce(dec_ce), .ue(dec_ue)
    );

    always_ff @(posedge clk) begin
      if (rst || raddr[p] == 5'd0) begin
        q_data[p] <= '0;
        q_ce[p]   <= 1'b0;
        q_ue[p]   <= 1'b0;
      end else begin
        q_data[p] <= dec_data;
        q_ce[p]   <= dec_ce;
        q_ue[p]   <= dec_ue;
      end
    end
  end

  assign ra_data = q_data[0];
  assign ra_ce   = q_ce[0];
  assign ra_ue   = q_ue[0];
  assign rb_data = q_data[1];
  assign rb_ce   = q_ce[1];
  assign rb_ue   = q_ue[1];
endmodule

// File: rtl/winreg_edac_chk.sv
module winreg_edac_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  cwp,
  input logic        wr_en,
  input logic [4:0]  ra_addr,
  input logic [4:0]  rb_addr,
  input logic [31:0] ra_data,
  input logic        ra_ce,
  input logic        ra_ue,
  input logic [31:0] rb_data,
  input logic        rb_ce,
  input logic        rb_ue
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ra_data == 32'd0 && rb_data == 32'd0 && !ra_ce && !ra_ue && !rb_ce && !rb_ue));

  assert_zero_reg_a_R5: assert property (@(posedge clk) disable iff (rst)
    (ra_addr == 5'd0) |=> (ra_data == 32'd0 && !ra_ce && !ra_ue));

  assert_zero_reg_b_R5: assert property (@(posedge clk) disable iff (rst)
    (rb_addr == 5'd0) |=> (rb_data == 32'd0 && !rb_ce && !rb_ue));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(ra_ce && ra_ue) && !(rb_ce && rb_ue));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) == 1'b0 && $past(rst, 2) == 1'b0 && $past(wr_en, 2) == 1'b0 &&
     $past(ra_addr) == $past(ra_addr, 2) && $past(cwp) == $past(cwp, 2))
    |-> $stable(ra_data));
endmodule

bind winreg_edac winreg_edac_chk u_chk (.*);

// File: tb/winreg_edac_bench.sv
module winreg_edac_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPHYS = 136;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cwp = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [38:0] wr_flip = '0;
  logic [4:0]  ra_addr = '0;
  logic [4:0]  rb_addr = '0;
  logic [31:0] ra_data, rb_data;
  logic        ra_ce, ra_ue, rb_ce, rb_ue;

  int tests = 0;
  int fails = 0;

  winreg_edac u_winreg_edac (
    .clk(clk), .rst(rst), .cwp(cwp), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_flip(wr_flip), .ra_addr(ra_addr), .rb_addr(rb_addr),
    .ra_data(ra_data), .ra_ce(ra_ce), .ra_ue(ra_ue),
    .rb_data(rb_data), .rb_ce(rb_ce), .rb_ue(rb_ue)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [31:0] m_data [NPHYS];
  logic [38:0] m_mask [NPHYS];
  logic [31:0] e_data [2];
  logic        e_ce [2];
  logic        e_ue [2];
  string       e_req [2];
  bit          running = 1'b0;

  function automatic int phys_of(int w, int r);
    if (r < 8) return r;
    if (r >= 24) return 8 + ((w + 1) % 8) * 16 + (r - 24);
    return 8 + w * 16 + (r - 8);
  endfunction

  initial begin
    for (int i = 0; i < NPHYS; i++) begin
      m_data[i] = '0;
      m_mask[i] = '0;
    end
    for (int p = 0; p < 2; p++) begin
      e_data[p] = '0; e_ce[p] = 1'b0; e_ue[p] = 1'b0; e_req[p] = "R1";
    end
  end

  always @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      int a;
      a = (p == 0) ? int'(ra_addr) : int'(rb_addr);
      if (rst) begin
        e_data[p] = '0; e_ce[p] = 1'b0; e_ue[p] = 1'b0; e_req[p] = "R1";
      end else if (a == 0) begin
        e_data[p] = '0; e_ce[p] = 1'b0; e_ue[p] = 1'b0; e_req[p] = "R5";
      end else begin
        int idx, wt;
        idx = phys_of(int'(cwp), a);
        wt  = $countones(m_mask[idx]);
        e_data[p] = m_data[idx];
        e_ce[p]   = (wt == 1);
        e_ue[p]   = (wt == 2);
        e_req[p]  = (wt == 1) ? "R8" : (wt == 2) ? "R9" : "R10";
      end
    end
    if (wr_en && wr_addr != 5'd0) begin
      int widx;
      widx = phys_of(int'(cwp), int'(wr_addr));
      m_data[widx] = wr_data;
      m_mask[widx] = wr_flip;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      for (int p = 0; p < 2; p++) begin
        logic [31:0] d;
        logic c, u;
        d = (p == 0) ? ra_data : rb_data;
        c = (p == 0) ? ra_ce : rb_ce;
        u = (p == 0) ? ra_ue : rb_ue;
        tests++;
        if (c !== e_ce[p] || u !== e_ue[p] || (!e_ue[p] && d !== e_data[p])) begin
          fails++;
          $display("FAIL %s model port%0d: data=%h ce=%b ue=%b expected data=%h ce=%b ue=%b",
                   e_req[p], p, d, c, u, e_data[p], e_ce[p], e_ue[p]);
        end
      end
    end
  end

  task automatic cyc(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                     input logic [38:0] wf, input logic [4:0] a, input logic [4:0] b,
                     input logic [2:0] w);
    wr_en = we; wr_addr = wa; wr_data = wd; wr_flip = wf;
    ra_addr = a; rb_addr = b; cwp = w;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] d, input logic c, input logic u,
                     input logic [31:0] xd, input logic xc, input logic xu);
    tests++;
    if (d !== xd || c !== xc || u !== xu) begin
      fails++;
      $display("FAIL %s: data=%h ce=%b ue=%b expected data=%h ce=%b ue=%b",
               req, d, c, u, xd, xc, xu);
    end
  endtask

  task automatic chk_ue(input string req, input logic c, input logic u);
    tests++;
    if (c !== 1'b0 || u !== 1'b1) begin
      fails++;
      $display("FAIL %s: ce=%b ue=%b expected ce=0 ue=1", req, c, u);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1", ra_data, ra_ce, ra_ue, 32'd0, 1'b0, 1'b0);
    chk("R1", rb_data, rb_ce, rb_ue, 32'd0, 1'b0, 1'b0);
    rst = 1'b0;
    for (int w = 0; w < 8; w++)
      for (int r = 1; r < 32; r++)
        cyc(1'b1, 5'(r), 32'd0, '0, 5'd0, 5'd0, 3'(w));
    running = 1'b1;

    // R3: globals shared across windows
    cyc(1'b1, 5'd5, 32'h0BAD_F00D, '0, 5'd0, 5'd0, 3'd2);
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd5, 5'd5, 3'd6);
    chk("R3", ra_data, ra_ce, ra_ue, 32'h0BAD_F00D, 1'b0, 1'b0);
    // R4: ins of window 7 are outs of window 0
    cyc(1'b1, 5'd24, 32'h7777_0024, '0, 5'd0, 5'd0, 3'd7);
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd8, 5'd24, 3'd0);
    chk("R4", ra_data, ra_ce, ra_ue, 32'h7777_0024, 1'b0, 1'b0);
    // R4: outs of window 2 seen as ins of window 1
    cyc(1'b1, 5'd15, 32'h2222_0015, '0, 5'd0, 5'd0, 3'd2);
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd31, 5'd0, 3'd1);
    chk("R4", ra_data, ra_ce, ra_ue, 32'h2222_0015, 1'b0, 1'b0);
    // R4: locals private
    cyc(1'b1, 5'd16, 32'hAAAA_0003, '0, 5'd0, 5'd0, 3'd3);
    cyc(1'b1, 5'd16, 32'hBBBB_0004, '0, 5'd0, 5'd0, 3'd4);
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd16, 5'd0, 3'd3);
    chk("R4", ra_data, ra_ce, ra_ue, 32'hAAAA_0003, 1'b0, 1'b0);
    // R5: write to r0 ignored
    cyc(1'b1, 5'd0, 32'hFFFF_FFFF, '0, 5'd0, 5'd0, 3'd1);
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd0, 5'd0, 3'd1);
    chk("R5", ra_data, ra_ce, ra_ue, 32'd0, 1'b0, 1'b0);
    // R6: same-cycle read returns old
    cyc(1'b1, 5'd9, 32'h1111_1111, '0, 5'd0, 5'd0, 3'd1);
    cyc(1'b1, 5'd9, 32'h2222_2222, '0, 5'd9, 5'd0, 3'd1);
    chk("R6", ra_data, ra_ce, ra_ue, 32'h1111_1111, 1'b0, 1'b0);
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd9, 5'd0, 3'd1);
    chk("R6", ra_data, ra_ce, ra_ue, 32'h2222_2222, 1'b0, 1'b0);
    // R7: independent ports
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd5, 5'd9, 3'd1);
    chk("R7", ra_data, ra_ce, ra_ue, 32'h0BAD_F00D, 1'b0, 1'b0);
    chk("R7", rb_data, rb_ce, rb_ue, 32'h2222_2222, 1'b0, 1'b0);
    // R8: single flip, data bit position and overall parity bit
    cyc(1'b1, 5'd10, 32'hDEAD_BEEF, 39'(1) << 17, 5'd0, 5'd0, 3'd0);
    cyc(1'b1, 5'd11, 32'h1234_5678, 39'(1), 5'd10, 5'd0, 3'd0);
    chk("R8", ra_data, ra_ce, ra_ue, 32'hDEAD_BEEF, 1'b1, 1'b0);
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd11, 5'd11, 3'd0);
    chk("R8", ra_data, ra_ce, ra_ue, 32'h1234_5678, 1'b1, 1'b0);
    chk("R7", rb_data, rb_ce, rb_ue, 32'h1234_5678, 1'b1, 1'b0);
    // R9: double flip
    cyc(1'b1, 5'd12, 32'hCAFE_0001, (39'(1) << 3) | (39'(1) << 20), 5'd0, 5'd0, 3'd0);
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd12, 5'd0, 3'd0);
    chk_ue("R9", ra_ce, ra_ue);
    // R10: clean rewrite
    cyc(1'b1, 5'd12, 32'hCAFE_0002, '0, 5'd0, 5'd0, 3'd0);
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd0, 5'd12, 3'd0);
    chk("R10", rb_data, rb_ce, rb_ue, 32'hCAFE_0002, 1'b0, 1'b0);

    // random traffic, checked against the model every cycle (R2)
    for (int n = 0; n < 3000; n++) begin
      logic [38:0] f;
      int sel;
      sel = $urandom_range(0, 9);
      f = '0;
      if (sel == 0) f = 39'(1) << $urandom_range(0, 38);
      else if (sel == 1) begin
        int b0, b1;
        b0 = $urandom_range(0, 38);
        b1 = (b0 + $urandom_range(1, 38)) % 39;
        f = (39'(1) << b0) | (39'(1) << b1);
      end
      cyc(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), $urandom, f,
          5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)), 3'($urandom_range(0, 7)));
    end

    rst = 1'b1;
    cyc(1'b0, 5'd0, 32'd0, '0, 5'd5, 5'd5, 3'd0);
    chk("R1", ra_data, ra_ce, ra_ue, 32'd0, 1'b0, 1'b0);
    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule